// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steers a microcontroller between four power levels: active, light sleep, deep sleep and stop. From its registered state it produces level enables for the core clock, the high-frequency clock tree, the low-frequency clock tree and each oscillator. The oscillators are the low-frequency crystal, the low-frequency RC, the ultra-low-frequency RC and the auxiliary high-frequency RC. It also drives memory retention, the GPIO pin-state latch, per-bank RAM power-down and the keep-on request for the DC-DC converter.

Software enters a low-power level from active by pulsing a sleep request together with a 2-bit target select. Any wake source returns the block to active. A data-transfer request from the radio controller lifts deep sleep or stop only as far as the light-sleep level, so that the high-frequency clocks run while the core stays off. When the controller signals that the transfer is done, the block drops back to the exact deep level it came from. The low-frequency settings of that origin level are kept while the transfer is served.

Top module: `pm_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, the block is active. `cur_mode`=0, all clock and oscillator enables are 1, and retention, pin latch and RAM power-down are 0.
- R2: An entry is taken only in active, when `sleep_req`=1 and `sleep_sel` is nonzero. Select 1 gives light sleep, 2 gives deep sleep and 3 gives stop. `cur_mode` shows that value one cycle later. Select 0 is ignored, and so is `sleep_req` in any other state.
- R3: At the light-sleep level (`cur_mode`=1), `core_clk_en`=0 while the high-frequency tree, the low-frequency tree and every oscillator are enabled.
- R4: In deep sleep (`cur_mode`=2), the core clock and the high-frequency tree are off, while the low-frequency tree and the crystal, RC and ultra-low oscillators are on.
- R5: In stop (`cur_mode`=3), the low-frequency tree, the low-frequency crystal and the low-frequency RC are off, and only `ulfrco_en` stays 1.
- R6: In deep sleep and stop, `auxhf_en` follows `adc_hf_req`. In every other state it is 1.
- R7: If any bit of `wake_src` is 1 in light sleep, deep sleep, stop or while a transfer is served, the block is active in the next cycle.
- R8: `xfer_req` in deep sleep or stop, with no wake, moves the block to the transfer level. That level reports `cur_mode`=1, with the high-frequency tree on, the core clock off, and the origin level's low-frequency enables kept. `xfer_req` in active or light sleep is ignored.
- R9: `xfer_done` while a transfer is served, with no wake, returns the block to the deep level it left. `xfer_done` in any other state is ignored.
- R10: When a wake source and `xfer_req` arrive in the same cycle in deep sleep or stop, the block goes to active.
- R11: `retain_en` and `pin_latch_en` are 1 exactly in deep sleep and stop.
- R12: `ram_pd` equals `ram_pd_mask` in deep sleep and stop, and is 0 otherwise.
- R13: `dcdc_en` equals `dcdc_keep` in deep sleep and stop, and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to enter a low-power level |
| sleep_sel | input | 2 | Target level: 1 light sleep, 2 deep sleep, 3 stop |
| wake_src | input | NUM_WAKE | Wake sources: peripheral irq, reset pin, power-on, async pin, I2C match, comparator edge |
| xfer_req | input | 1 | Radio controller data-transfer request |
| xfer_done | input | 1 | Radio controller transfer complete |
| adc_hf_req | input | 1 | ADC on-demand request for the auxiliary HF oscillator |
| ram_pd_mask | input | NUM_BANKS | Banks to power down in deep levels |
| dcdc_keep | input | 1 | Keep the DC-DC converter on in deep levels |
| cur_mode | output | 2 | Reported level: 0 active, 1 light sleep, 2 deep sleep, 3 stop |
| core_clk_en | output | 1 | Core clock enable |
| hf_tree_en | output | 1 | High-frequency clock tree enable |
| lf_tree_en | output | 1 | Low-frequency clock tree enable |
| lfxo_en | output | 1 | Low-frequency crystal oscillator enable |
| lfrco_en | output | 1 | Low-frequency RC oscillator enable |
| ulfrco_en | output | 1 | Ultra-low-frequency RC oscillator enable |
| auxhf_en | output | 1 | Auxiliary high-frequency RC oscillator enable |
| retain_en | output | 1 | Memory and register retention |
| pin_latch_en | output | 1 | GPIO pin-state latch |
| ram_pd | output | NUM_BANKS | Per-bank RAM power-down |
| dcdc_en | output | 1 | DC-DC converter enable |

## Verification
In deep sleep or stop, a wake source and a transfer request can both be seen in the same cycle. The bench provokes this by pulsing `xfer_req` together with a `wake_src` bit in one cycle, and it does so from both deep levels. It judges the result by the reference model's decision that the wake wins, so the next cycle must show `cur_mode`=0 and not the transfer level. A second overlap is a wake pulsed during a transfer at the same time as `xfer_done`, where the block must reach active and not return to the deep level.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_NAP  = 3'd1,
        ST_DEEP = 3'd2,
        ST_HALT = 3'd3,
        ST_XFER = 3'd4
    } pm_state_e;

    typedef struct packed {
        logic core_clk;
        logic hf_tree;
        logic lf_tree;
        logic lfxo;
        logic lfrco;
        logic ulfrco;
        logic auxhf;
        logic retain;
        logic pin_latch;
        logic dcdc;
    } pm_ctrl_t;

    function automatic logic is_deep(pm_state_e s);
        return (s == ST_DEEP) || (s == ST_HALT);
    endfunction

    function automatic logic [1:0] level_of(pm_state_e s);
        logic [1:0] lvl;
        case (s)
            ST_NAP, ST_XFER: lvl = 2'd1;
            ST_DEEP:         lvl = 2'd2;
            ST_HALT:         lvl = 2'd3;
            default:         lvl = 2'd0;
        endcase
        return lvl;
    endfunction

    function automatic pm_state_e target_of(logic [1:0] sel);
        pm_state_e t;
        case (sel)
            2'd1:    t = ST_NAP;
            2'd2:    t = ST_DEEP;
            2'd3:    t = ST_HALT;
            default: t = ST_RUN;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/pm_next_state.sv
module pm_next_state
    import pm_pkg::*;
(
    input  pm_state_e  state,
    input  pm_state_e  origin,
    input  logic       sleep_req,
    input  logic [1:0] sleep_sel,
    input  logic       wake_any,
    input  logic       xfer_req,
    input  logic       xfer_done,
    output pm_state_e  state_nxt,
    output pm_state_e  origin_nxt
);

    always_comb begin
        state_nxt  = state;
        origin_nxt = origin;
        case (state)
            ST_RUN: begin
                if (sleep_req && (sleep_sel != 2'd0))
                    state_nxt = target_of(sleep_sel);
            end
            ST_NAP: begin
                if (wake_any)
                    state_nxt = ST_RUN;
            end
            ST_DEEP, ST_HALT: begin
                if (wake_any) begin
                    state_nxt = ST_RUN;
                end else if (xfer_req) begin
                    state_nxt  = ST_XFER;
                    origin_nxt = state;
                end
            end
            ST_XFER: begin
                if (wake_any)
                    state_nxt = ST_RUN;
                else if (xfer_done)
                    state_nxt = origin;
            end
            default: state_nxt = ST_RUN;
        endcase
    end

endmodule

// File: rtl/pm_out_decode.sv
module pm_out_decode
    import pm_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  pm_state_e            state,
    input  pm_state_e            origin,
    input  logic                 adc_hf_req,
    input  logic [NUM_BANKS-1:0] ram_pd_mask,
    input  logic                 dcdc_keep,
    output pm_ctrl_t             ctrl,
    output logic [NUM_BANKS-1:0] ram_pd
);

    logic deep_lvl;
    logic lf_keep;

    assign deep_lvl = is_deep(state);
    // While serving a transfer, low-frequency sources follow the origin level.
    assign lf_keep  = (state == ST_XFER) ? (origin == ST_DEEP) : (state != ST_HALT);

    always_comb begin
        ctrl.core_clk  = (state == ST_RUN);
        ctrl.hf_tree   = !deep_lvl;
        ctrl.lf_tree   = lf_keep;
        ctrl.lfxo      = lf_keep;
        ctrl.lfrco     = lf_keep;
        ctrl.ulfrco    = 1'b1;
        ctrl.auxhf     = deep_lvl ? adc_hf_req : 1'b1;
        ctrl.retain    = deep_lvl;
        ctrl.pin_latch = deep_lvl;
        ctrl.dcdc      = deep_lvl ? dcdc_keep : 1'b1;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign ram_pd[b] = deep_lvl & ram_pd_mask[b];
    end

endmodule

// File: rtl/pm_seq.sv
module pm_seq
    import pm_pkg::*;
#(
    parameter int NUM_WAKE  = 6,
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sleep_req,
    input  logic [1:0]           sleep_sel,
    input  logic [NUM_WAKE-1:0]  wake_src,
    input  logic                 xfer_req,
    input  logic                 xfer_done,
    input  logic                 adc_hf_req,
    input  logic [NUM_BANKS-1:0] ram_pd_mask,
    input  logic                 dcdc_keep,
    output logic [1:0]           cur_mode,
    output logic                 core_clk_en,
    output logic                 hf_tree_en,
    output logic                 lf_tree_en,
    output logic                 lfxo_en,
    output logic                 lfrco_en,
    output logic                 ulfrco_en,
    output logic                 auxhf_en,
    output logic                 retain_en,
    output logic                 pin_latch_en,
    output logic [NUM_BANKS-1:0] ram_pd,
    output logic                 dcdc_en
);

    pm_state_e state_q, state_d;
    pm_state_e origin_q, origin_d;
    pm_ctrl_t  ctrl;
    logic      wake_any;

    assign wake_any = |wake_src;

    pm_next_state u_next (
        .state     (state_q),
        .origin    (origin_q),
        .sleep_req (sleep_req),
        .sleep_sel (sleep_sel),
        .wake_any  (wake_any),
        .xfer_req  (xfer_req),
        .xfer_done (xfer_done),
        .state_nxt (state_d),
        .origin_nxt(origin_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_RUN;
            origin_q <= ST_DEEP;
        end else begin
            state_q  <= state_d;
            origin_q <= origin_d;
        end
    end

    pm_out_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .state      (state_q),
        .origin     (origin_q),
        .adc_hf_req (adc_hf_req),
        .ram_pd_mask(ram_pd_mask),
        .dcdc_keep  (dcdc_keep),
        .ctrl       (ctrl),
        .ram_pd     (ram_pd)
    );

    assign cur_mode     = level_of(state_q);
    assign core_clk_en  = ctrl.core_clk;
    assign hf_tree_en   = ctrl.hf_tree;
    assign lf_tree_en   = ctrl.lf_tree;
    assign lfxo_en      = ctrl.lfxo;
    assign lfrco_en     = ctrl.lfrco;
    assign ulfrco_en    = ctrl.ulfrco;
    assign auxhf_en     = ctrl.auxhf;
    assign retain_en    = ctrl.retain;
    assign pin_latch_en = ctrl.pin_latch;
    assign dcdc_en      = ctrl.dcdc;

    assert_entry_gate_R2: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 2'd0 && !(sleep_req && sleep_sel != 2'd0)) |=> (cur_mode == 2'd0));

    assert_wake_to_run_R7: assert property (@(posedge clk) disable iff (rst)
        (cur_mode != 2'd0 && wake_any) |=> (cur_mode == 2'd0 && core_clk_en));

    assert_xfer_level_R8: assert property (@(posedge clk) disable iff (rst)
        (cur_mode[1] && !wake_any && xfer_req) |=> (cur_mode == 2'd1 && hf_tree_en && !core_clk_en));

    assert_xfer_return_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_XFER && !wake_any && xfer_done) |=> (cur_mode == level_of($past(origin_q))));

    assert_stop_lf_off_R5: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 2'd3) |-> (!lf_tree_en && !lfxo_en && !lfrco_en && ulfrco_en));

    assert_retain_deep_R11: assert property (@(posedge clk) disable iff (rst)
        (retain_en || pin_latch_en) |-> cur_mode[1]);

endmodule

// File: tb/tb_pm_seq.sv
module tb_pm_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 6;
    localparam int NB = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 1'b0;
    logic [1:0] sleep_sel = 2'd0;
    logic [NW-1:0] wake_src = '0;
    logic xfer_req = 1'b0, xfer_done = 1'b0;
    logic adc_hf_req = 1'b0;
    logic [NB-1:0] ram_pd_mask = '0;
    logic dcdc_keep = 1'b0;
    logic [1:0] cur_mode;
    logic core_clk_en, hf_tree_en, lf_tree_en, lfxo_en, lfrco_en, ulfrco_en;
    logic auxhf_en, retain_en, pin_latch_en, dcdc_en;
    logic [NB-1:0] ram_pd;

    int checks = 0;
    int fails = 0;
    int m = 0;   // model: 0 run, 1 light, 2 deep, 3 stop, 4 transfer
    int r = 2;   // model origin level for transfer

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_seq #(.NUM_WAKE(NW), .NUM_BANKS(NB)) dut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .sleep_sel(sleep_sel),
        .wake_src(wake_src), .xfer_req(xfer_req), .xfer_done(xfer_done),
        .adc_hf_req(adc_hf_req), .ram_pd_mask(ram_pd_mask), .dcdc_keep(dcdc_keep),
        .cur_mode(cur_mode), .core_clk_en(core_clk_en), .hf_tree_en(hf_tree_en),
        .lf_tree_en(lf_tree_en), .lfxo_en(lfxo_en), .lfrco_en(lfrco_en),
        .ulfrco_en(ulfrco_en), .auxhf_en(auxhf_en), .retain_en(retain_en),
        .pin_latch_en(pin_latch_en), .ram_pd(ram_pd), .dcdc_en(dcdc_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    // Reference model: behavioural transition per clock.
    always @(posedge clk) begin
        if (rst) begin
            m = 0; r = 2;
        end else begin
            if (m == 0) begin
                if (sleep_req && sleep_sel != 0) m = sleep_sel;
            end else if (wake_src != 0) begin
                m = 0;
            end else if ((m == 2 || m == 3) && xfer_req) begin
                r = m; m = 4;
            end else if (m == 4 && xfer_done) begin
                m = r;
            end
        end
    end

    // Compare every output with the model on every falling edge.
    always @(negedge clk) begin
        if (!rst) begin
            automatic bit lo = (m == 2 || m == 3);
            automatic int lfon = (m <= 2 || (m == 4 && r == 2)) ? 1 : 0;
            chk("R2 mode", cur_mode, (m == 4) ? 1 : m);
            chk(lo ? "R4 core" : "R3 core", core_clk_en, (m == 0) ? 1 : 0);
            chk(lo ? "R4 hf" : "R8 hf", hf_tree_en, lo ? 0 : 1);
            chk("R5 lftree", lf_tree_en, lfon);
            chk("R5 lfxo", lfxo_en, lfon);
            chk("R5 lfrco", lfrco_en, lfon);
            chk("R5 ulfrco", ulfrco_en, 1);
            chk("R6 aux", auxhf_en, lo ? int'(adc_hf_req) : 1);
            chk("R11 retain", retain_en, lo ? 1 : 0);
            chk("R11 latch", pin_latch_en, lo ? 1 : 0);
            chk("R12 rampd", ram_pd, lo ? int'(ram_pd_mask) : 0);
            chk("R13 dcdc", dcdc_en, lo ? int'(dcdc_keep) : 1);
        end
    end

    // Drive one cycle of inputs from a falling edge, return just after the next rising edge.
    task automatic step(input bit sr, input int sel, input int wk, input bit xr, input bit xd);
        @(negedge clk);
        sleep_req = sr; sleep_sel = sel[1:0]; wake_src = wk[NW-1:0];
        xfer_req = xr; xfer_done = xd;
        @(posedge clk); #1;
        sleep_req = 0; sleep_sel = 0; wake_src = '0; xfer_req = 0; xfer_done = 0;
    endtask

    bit finished = 0;

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset mode", cur_mode, 0);
        chk("R1 reset core", core_clk_en, 1);
        chk("R1 reset retain", retain_en, 0);
        @(negedge clk); rst = 0;
        @(posedge clk); #1;
        chk("R1 after reset hf", hf_tree_en, 1);

        // light sleep, ignored transfer, wake
        step(1, 1, 0, 0, 0);     chk("R3 light", cur_mode, 1);
        step(0, 0, 0, 1, 0);     chk("R8 xfer ignored in light", cur_mode, 1);
        step(1, 3, 0, 0, 0);     chk("R2 entry ignored in light", cur_mode, 1);
        step(0, 0, 6'b001000, 0, 0); chk("R7 wake light", cur_mode, 0);
        step(1, 0, 0, 0, 0);     chk("R2 select 0 ignored", cur_mode, 0);
        step(0, 0, 0, 1, 1);     chk("R8 xfer ignored in active", cur_mode, 0);

        // deep sleep with transfer round trip
        adc_hf_req = 0; ram_pd_mask = 4'b0101; dcdc_keep = 1;
        step(1, 2, 0, 0, 0);     chk("R4 deep", cur_mode, 2);
        chk("R12 deep mask", ram_pd, 4'b0101);
        step(0, 0, 0, 0, 1);     chk("R9 done ignored in deep", cur_mode, 2);
        @(negedge clk); adc_hf_req = 1;
        @(posedge clk); #1;      chk("R6 aux on demand", auxhf_en, 1);
        step(0, 0, 0, 1, 0);     chk("R8 deep xfer", cur_mode, 1);
        chk("R8 lf kept", lf_tree_en, 1);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1);     chk("R9 back to deep", cur_mode, 2);
        step(0, 0, 6'b000001, 0, 0); chk("R7 wake deep", cur_mode, 0);

        // stop with transfer, then wake during transfer
        adc_hf_req = 0; ram_pd_mask = 4'b1010; dcdc_keep = 0;
        step(1, 3, 0, 0, 0);     chk("R5 stop", cur_mode, 3);
        chk("R13 dcdc off", dcdc_en, 0);
        step(0, 0, 0, 1, 0);     chk("R8 stop xfer", cur_mode, 1);
        chk("R8 lf stays off", lf_tree_en, 0);
        step(0, 0, 0, 0, 1);     chk("R9 back to stop", cur_mode, 3);
        step(0, 0, 0, 1, 0);
        step(0, 0, 6'b010000, 0, 1); chk("R7 wake beats done", cur_mode, 0);

        // simultaneous wake and transfer request
        step(1, 3, 0, 0, 0);
        step(0, 0, 6'b100000, 1, 0); chk("R10 wake wins stop", cur_mode, 0);
        step(1, 2, 0, 0, 0);
        step(0, 0, 6'b000100, 1, 0); chk("R10 wake wins deep", cur_mode, 0);

        // every wake source from deep sleep
        for (int i = 0; i < NW; i++) begin
            step(1, 2, 0, 0, 0);
            step(0, 0, 1 << i, 0, 0);
            chk("R7 each source", cur_mode, 0);
        end

        repeat (3) @(posedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule